// File: doc/BRIEF.md
# Repeater Key-List Hash Message Formatter

This block turns the downstream key list reported by a content-protection repeater into the word stream that a hash engine consumes when it checks that list. A controller starts a run by giving the device count and the 16-bit topology status word. The formatter then takes the 5-byte device keys one byte at a time through a valid/ready handshake. It packs the keys big-endian into 32-bit words and carries any bytes that do not fit into the next word. After the keys it appends the status bytes and eight byte slots reserved for the secret value.

The secret never enters this block. Its slots are sent as zero bytes, and each word carries a tag that gives how many of its bytes are list text (keys or status). This lets the hash engine merge in its own secret at the right place. After the message the block pads with zero words up to the second-to-last word of a 64-byte block. The final word holds the message length in bits and is flagged as last. The word that opens each 64-byte block is also flagged, so that the engine can reload its mode at that boundary.

Top module: `hmf_formatter`

## Requirements
- R1: Message bytes are ordered as all key bytes in arrival order, then status bits 15:8, then status bits 7:0, then 8 secret slots. In a full word the earliest byte sits in bits 31:24.
- R2: Key bytes are packed with no gaps. A key that does not fit in the current word continues in the next word.
- R3: `out_tag` gives the number of text bytes in each word. With L = (5·N) mod 4 bytes of the last key left over, the tail words starting at word floor(5·N/4) carry tags 2,0,0 for L=0, 3,0,0 for L=1, 4,0,0 for L=2, and 4,1,0,0 for L=3. Padding and length words carry tag 0.
- R4: A word with 1 to 3 text bytes has those bytes right-aligned in the low bits. Every secret slot is zero.
- R5: After the message, zero words follow until the word position within the 64-byte block (word index mod 16) reaches 15.
- R6: The word at position 15 after the padding is (5·N+10)·8, with `out_last` high on it and on no other word. The block goes idle once that word is taken.
- R7: `out_first` is high exactly on words whose index from the start of the run is a multiple of 16.
- R8: While `out_valid` is high and `out_ready` is low, the word and its flags stay unchanged. No word is lost or duplicated under any pattern of stalls on either side.
- R9: A start with device count 0 makes `err` pulse high for one cycle, starting the cycle after the start. It produces no output word, never raises `key_ready`, and leaves `busy` low.
- R10: After reset, `out_valid`, `key_ready`, `busy` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a run; ignored while busy |
| dev_count | input | 7 | Number of device keys N |
| status | input | 16 | Topology status word, bits 15:8 sent first |
| key_valid | input | 1 | Key byte available |
| key_byte | input | 8 | Key byte |
| key_ready | output | 1 | Key byte accepted this cycle when valid |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Message word |
| out_tag | output | 3 | Count of text bytes in the word |
| out_first | output | 1 | Word opens a 64-byte block |
| out_last | output | 1 | Length word, end of the run |
| busy | output | 1 | Run in progress or word pending |
| err | output | 1 | Zero device count rejected |

## Verification
The assertions assume that exactly as many key bytes as 5·N are offered during a run and that `start` is only meaningful while `busy` is low. They also assume the consumer never sees a word change while it stalls, and that the controller keeps the secret-slot and flush steps apart from key pushes. The stimulus stops offering key bytes once 5·N have been accepted. It raises `start` only when the block is idle, and it throttles both handshakes with fixed periodic gap patterns, so that back-pressure reaches words in the middle of the message, in the tail and in the padding.

// File: rtl/hmf_pkg.sv
package hmf_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_KEYS,
      PH_STAT,
      PH_SECRET,
      PH_FLUSH,
      PH_PAD
   } hmf_phase_e;
endpackage

// File: rtl/hmf_word_acc.sv
module hmf_word_acc #(
   parameter int WORD_BYTES    = 4,
   parameter bit PARTIAL_RIGHT = 1'b1,
   localparam int WORD_W = WORD_BYTES * 8,
   localparam int FILL_W = $clog2(WORD_BYTES),
   localparam int TAG_W  = $clog2(WORD_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [7:0]        byte_i,
   input  logic              text_i,
   input  logic              flush_i,
   output logic              done_o,
   output logic [WORD_W-1:0] word_o,
   output logic [TAG_W-1:0]  tag_o
);
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] merged;
   logic [FILL_W-1:0] fill_q;
   logic [TAG_W-1:0]  txt_q;
   logic [TAG_W-1:0]  tag_n;

   initial assert (WORD_BYTES >= 2) else $error("hmf_word_acc: WORD_BYTES must be at least 2");

   always_comb begin
      merged = acc_q;
      tag_n  = txt_q;
      if (push_i) begin
         merged = acc_q | ({{(WORD_W-8){1'b0}}, byte_i} << (8 * (WORD_BYTES - 1 - int'(fill_q))));
         tag_n  = txt_q + TAG_W'(text_i);
      end
   end

   assign done_o = (push_i && fill_q == FILL_W'(WORD_BYTES - 1)) || (flush_i && fill_q != '0);
   assign tag_o  = tag_n;

   generate
      if (PARTIAL_RIGHT) begin : g_right
         always_comb begin
            if (tag_n != '0 && int'(tag_n) < WORD_BYTES)
               word_o = merged >> (8 * (WORD_BYTES - int'(tag_n)));
            else
               word_o = merged;
         end
      end else begin : g_left
         assign word_o = merged;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         fill_q <= '0;
         txt_q  <= '0;
      end else if (done_o) begin
         acc_q  <= '0;
         fill_q <= '0;
         txt_q  <= '0;
      end else if (push_i) begin
         acc_q  <= merged;
         fill_q <= fill_q + FILL_W'(1);
         txt_q  <= tag_n;
      end
   end

   // R4: a flush never coincides with a byte push
   assert_flush_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !push_i);

   // R4: text bytes only ever follow text bytes inside a word
   assert_text_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && text_i) |-> (int'(txt_q) == int'(fill_q)));
endmodule

// File: rtl/hmf_out_slot.sv
module hmf_out_slot #(
   parameter int WORD_BYTES = 4,
   parameter int BLK_WORDS  = 16,
   localparam int WORD_W = WORD_BYTES * 8,
   localparam int TAG_W  = $clog2(WORD_BYTES + 1),
   localparam int POS_W  = $clog2(BLK_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_pos_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic              last_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] word_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic              first_o,
   output logic              last_o,
   output logic [POS_W-1:0]  pos_o
);
   logic [POS_W-1:0] pos_q;

   initial assert (BLK_WORDS >= 2 && (BLK_WORDS & (BLK_WORDS - 1)) == 0)
      else $error("hmf_out_slot: BLK_WORDS must be a power of two");

   assign pos_o = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         word_o  <= '0;
         tag_o   <= '0;
         first_o <= 1'b0;
         last_o  <= 1'b0;
         pos_q   <= '0;
      end else begin
         if (load_i) begin
            valid_o <= 1'b1;
            word_o  <= word_i;
            tag_o   <= tag_i;
            first_o <= (pos_q == '0);
            last_o  <= last_i;
            pos_q   <= pos_q + POS_W'(1);
         end else if (ready_i) begin
            valid_o <= 1'b0;
         end
         if (clr_pos_i) pos_q <= '0;
      end
   end

   // R8: a new word only enters a free or draining slot
   assert_load_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (!valid_o || ready_i));

   // R8: a stalled word is held unchanged
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(word_o) && $stable(tag_o) && $stable(last_o)));

   // R6: the length word lands on the final position of a block
   assert_last_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && last_i) |-> (pos_q == POS_W'(BLK_WORDS - 1)));
endmodule

// File: rtl/hmf_formatter.sv
module hmf_formatter #(
   parameter int DEV_CNT_W     = 7,
   parameter int WORD_BYTES    = 4,
   parameter int BLK_BYTES     = 64,
   parameter bit PARTIAL_RIGHT = 1'b1,
   localparam int WORD_W    = WORD_BYTES * 8,
   localparam int TAG_W     = $clog2(WORD_BYTES + 1),
   localparam int BLK_WORDS = BLK_BYTES / WORD_BYTES,
   localparam int POS_W     = $clog2(BLK_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [DEV_CNT_W-1:0] dev_count,
   input  logic [15:0]          status,
   input  logic                 key_valid,
   input  logic [7:0]           key_byte,
   output logic                 key_ready,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [WORD_W-1:0]    out_word,
   output logic [TAG_W-1:0]     out_tag,
   output logic                 out_first,
   output logic                 out_last,
   output logic                 busy,
   output logic                 err
);
   import hmf_pkg::*;

   localparam int KEY_BYTES    = 5;
   localparam int STAT_BYTES   = 2;
   localparam int SECRET_BYTES = 8;
   localparam int REM_W        = DEV_CNT_W + 3;

   initial assert (WORD_BYTES == 4 && BLK_BYTES % WORD_BYTES == 0)
      else $error("hmf_formatter: 32-bit words and whole-word blocks required");

   hmf_phase_e           phase_q;
   logic [REM_W-1:0]     rem_q;
   logic [3:0]           sub_q;
   logic [DEV_CNT_W-1:0] cnt_q;
   logic [15:0]          stat_q;
   logic                 err_q;

   logic                 adv, accept, push, ptext, flush, pad_load, pad_last, load;
   logic [7:0]           pbyte;
   logic                 acc_done;
   logic [WORD_W-1:0]    acc_word, load_word, msg_bits;
   logic [TAG_W-1:0]     acc_tag, load_tag;
   logic [POS_W-1:0]     pos;

   assign adv      = !out_valid || out_ready;
   assign accept   = (phase_q == PH_IDLE) && start && !out_valid;
   assign msg_bits = WORD_W'((int'(cnt_q) * KEY_BYTES + STAT_BYTES + SECRET_BYTES) * 8);

   always_comb begin
      push      = 1'b0;
      pbyte     = '0;
      ptext     = 1'b0;
      flush     = 1'b0;
      pad_load  = 1'b0;
      pad_last  = 1'b0;
      key_ready = 1'b0;
      case (phase_q)
         PH_KEYS: begin
            key_ready = adv;
            push      = adv && key_valid;
            pbyte     = key_byte;
            ptext     = 1'b1;
         end
         PH_STAT: begin
            push  = adv;
            pbyte = sub_q[0] ? stat_q[7:0] : stat_q[15:8];
            ptext = 1'b1;
         end
         PH_SECRET: push = adv;
         PH_FLUSH:  flush = adv;
         PH_PAD: begin
            pad_load = adv;
            pad_last = (pos == POS_W'(BLK_WORDS - 1));
         end
         default: ;
      endcase
   end

   assign load      = acc_done || pad_load;
   assign load_word = pad_load ? (pad_last ? msg_bits : '0) : acc_word;
   assign load_tag  = pad_load ? '0 : acc_tag;

   hmf_word_acc #(.WORD_BYTES(WORD_BYTES), .PARTIAL_RIGHT(PARTIAL_RIGHT)) u_acc (
      .clk(clk), .rst_n(rst_n), .push_i(push), .byte_i(pbyte), .text_i(ptext),
      .flush_i(flush), .done_o(acc_done), .word_o(acc_word), .tag_o(acc_tag)
   );

   hmf_out_slot #(.WORD_BYTES(WORD_BYTES), .BLK_WORDS(BLK_WORDS)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr_pos_i(accept), .load_i(load),
      .word_i(load_word), .tag_i(load_tag), .last_i(pad_load && pad_last),
      .ready_i(out_ready), .valid_o(out_valid), .word_o(out_word), .tag_o(out_tag),
      .first_o(out_first), .last_o(out_last), .pos_o(pos)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         rem_q   <= '0;
         sub_q   <= '0;
         cnt_q   <= '0;
         stat_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= accept && (dev_count == '0);
         case (phase_q)
            PH_IDLE: if (accept && dev_count != '0) begin
               cnt_q   <= dev_count;
               stat_q  <= status;
               rem_q   <= REM_W'(dev_count) * REM_W'(KEY_BYTES);
               phase_q <= PH_KEYS;
            end
            PH_KEYS: if (push) begin
               rem_q <= rem_q - REM_W'(1);
               if (rem_q == REM_W'(1)) begin
                  phase_q <= PH_STAT;
                  sub_q   <= '0;
               end
            end
            PH_STAT: if (push) begin
               sub_q <= sub_q + 4'd1;
               if (sub_q == 4'(STAT_BYTES - 1)) begin
                  phase_q <= PH_SECRET;
                  sub_q   <= '0;
               end
            end
            PH_SECRET: if (push) begin
               sub_q <= sub_q + 4'd1;
               if (sub_q == 4'(SECRET_BYTES - 1)) phase_q <= PH_FLUSH;
            end
            PH_FLUSH: if (adv) phase_q <= PH_PAD;
            PH_PAD:   if (adv && pad_last) phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase_q != PH_IDLE) || out_valid;
   assign err  = err_q;

   // R9: a rejected start leaves the output side silent
   assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!out_valid && !key_ready));
endmodule

// File: tb/hmf_formatter_test.sv
module hmf_formatter_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  dev_count = '0;
   logic [15:0] status = '0;
   logic        key_valid = 1'b0;
   logic [7:0]  key_byte = '0;
   logic        key_ready;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_word;
   logic [2:0]  out_tag;
   logic        out_first, out_last, busy, err;

   int checks = 0;
   int fails  = 0;

   hmf_formatter uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count), .status(status),
      .key_valid(key_valid), .key_byte(key_byte), .key_ready(key_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_tag(out_tag),
      .out_first(out_first), .out_last(out_last), .busy(busy), .err(err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] keyb(input int seed, input int i);
      return 8'((seed * 29 + i * 7 + 3) % 256);
   endfunction

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
      chk(busy === 1'b0, "R10", "busy in reset", 32'(busy), 32'd0);
      chk(key_ready === 1'b0, "R10", "key_ready in reset", 32'(key_ready), 32'd0);
      chk(err === 1'b0, "R10", "err in reset", 32'(err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_msg(input int n, input logic [15:0] st, input int seed, input bit gaps);
      logic [7:0]  mb [0:255];
      bit          mt [0:255];
      logic [31:0] ew [0:63];
      int          et [0:63];
      bit          ef [0:63];
      bit          el [0:63];
      int          rt [0:63];
      int          exp_t [4];
      int nb, nm, nw, lo, ts, tl, kp, got, cyc;
      bit stalled;
      logic [31:0] hold_w;
      nb = 5 * n + 10;
      nm = (nb + 3) / 4;
      lo = (5 * n) % 4;
      ts = (5 * n - lo) / 4;
      for (int i = 0; i < 256; i++) begin mb[i] = '0; mt[i] = 1'b0; end
      for (int i = 0; i < 5 * n; i++) begin mb[i] = keyb(seed, i); mt[i] = 1'b1; end
      mb[5*n] = st[15:8];  mt[5*n] = 1'b1;
      mb[5*n+1] = st[7:0]; mt[5*n+1] = 1'b1;
      for (int w = 0; w < nm; w++) begin
         logic [31:0] v;
         int tg;
         v = '0;
         tg = 0;
         for (int b = 0; b < 4; b++) begin
            v = {v[23:0], mb[4*w+b]};
            if (mt[4*w+b]) tg++;
         end
         if (tg > 0 && tg < 4) v = v >> (8 * (4 - tg));
         ew[w] = v; et[w] = tg; el[w] = 1'b0;
      end
      nw = nm;
      while (nw % 16 != 15) begin ew[nw] = '0; et[nw] = 0; el[nw] = 1'b0; nw++; end
      ew[nw] = 32'((5 * n + 10) * 8); et[nw] = 0; el[nw] = 1'b1; nw++;
      for (int w = 0; w < nw; w++) begin ef[w] = (w % 16 == 0); rt[w] = -1; end

      start = 1'b1; dev_count = 7'(n); status = st;
      @(negedge clk);
      start = 1'b0;
      kp = 0; got = 0; cyc = 0; stalled = 1'b0; hold_w = '0;
      while (got < nw && cyc < 4000) begin
         out_ready = gaps ? (cyc % 3 != 1) : 1'b1;
         key_valid = (kp < 5 * n) && (gaps ? (cyc % 5 != 3) : 1'b1);
         key_byte  = keyb(seed, kp);
         #1;
         if (stalled)
            chk(out_valid === 1'b1 && out_word === hold_w, "R8", "word held in stall", out_word, hold_w);
         if (out_valid && out_ready) begin
            string rq;
            if (got < ts) rq = (got == 0) ? "R1" : "R2";
            else if (got < nm) rq = "R4";
            else if (got < nw - 1) rq = "R5";
            else rq = "R6";
            chk(out_word === ew[got], rq, $sformatf("n=%0d word %0d data", n, got), out_word, ew[got]);
            chk(int'(out_tag) == et[got], "R3", $sformatf("n=%0d word %0d tag", n, got), 32'(out_tag), 32'(et[got]));
            chk(out_first === ef[got], "R7", $sformatf("n=%0d word %0d first", n, got), 32'(out_first), 32'(ef[got]));
            chk(out_last === el[got], "R6", $sformatf("n=%0d word %0d last", n, got), 32'(out_last), 32'(el[got]));
            rt[got] = int'(out_tag);
            got++;
         end
         stalled = out_valid && !out_ready;
         hold_w  = out_word;
         if (key_valid && key_ready) kp++;
         cyc++;
         @(negedge clk);
      end
      key_valid = 1'b0;
      out_ready = 1'b1;
      if (cyc >= 4000) chk(1'b0, "R8", "watchdog on run", 32'(got), 32'(nw));
      chk(got == nw, "R5", $sformatf("n=%0d word count", n), 32'(got), 32'(nw));
      chk(kp == 5 * n, "R2", $sformatf("n=%0d key bytes taken", n), 32'(kp), 32'(5 * n));
      case (lo)
         0: begin exp_t = '{2, 0, 0, 0}; tl = 3; end
         1: begin exp_t = '{3, 0, 0, 0}; tl = 3; end
         2: begin exp_t = '{4, 0, 0, 0}; tl = 3; end
         default: begin exp_t = '{4, 1, 0, 0}; tl = 4; end
      endcase
      for (int k = 0; k < tl; k++)
         chk(rt[ts+k] == exp_t[k], "R3", $sformatf("n=%0d leftover %0d tail tag %0d", n, lo, k),
             32'(rt[ts+k]), 32'(exp_t[k]));
      chk(busy === 1'b0 && out_valid === 1'b0, "R6", "idle after length word", 32'(busy), 32'd0);
   endtask

   task automatic test_zero_count();
      out_ready = 1'b1;
      start = 1'b1; dev_count = '0; status = 16'hFFFF;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1, "R9", "err pulse after zero count", 32'(err), 32'd1);
      chk(busy === 1'b0, "R9", "busy after zero count", 32'(busy), 32'd0);
      @(negedge clk);
      chk(err === 1'b0, "R9", "err lasts one cycle", 32'(err), 32'd0);
      for (int i = 0; i < 20; i++) begin
         chk(out_valid === 1'b0 && key_ready === 1'b0, "R9", "no output after zero count",
             32'({out_valid, key_ready}), 32'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R8 global watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      test_reset();
      run_msg(1, 16'hA55A, 3, 1'b0);
      run_msg(2, 16'h0102, 5, 1'b1);
      run_msg(3, 16'hBEEF, 7, 1'b0);
      run_msg(4, 16'h1234, 11, 1'b1);
      run_msg(12, 16'h0F0F, 13, 1'b1);
      test_zero_count();
      run_msg(3, 16'hC3C3, 17, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule